// File: doc/BRIEF.md
# Root Hub Port Status and Control Register Bank

This block holds one 16-bit status and control word for each downstream port of a root hub. Software reaches the words through a simple indexed write port and a combinational indexed read port. The hub-side logic reports device arrival and departure through per-port attach and detach strobes, and gives the device speed with each arrival. The bank keeps, for each port, the connect state, the enable state, a change flag for each of those two, a low-speed marker and a port-reset bit.

Writes are masked. Software can drive only the enable and port-reset bits. The two change flags clear when 1 is written to them. Software cannot set any status bit. When the port-reset bit goes from 0 to 1 because of a write, or when a bus-wide reset command arrives while a device is connected, the bank raises a one-cycle reset request toward that port's device. The number of ports is a parameter. An index with no port behind it reads back a fixed pattern and ignores writes.

Top module: `port_sc_bank`

## Requirements
- R1: After reset every implemented port reads 0x0080 and no reset request is raised.
- R2: Read layout: bit 0 connected, bit 1 connect changed, bit 2 enabled, bit 3 enable changed, bit 7 constant 1, bit 8 low-speed device, bit 9 port reset. Every other bit reads 0.
- R3: A write to a port takes bits 2 and 9 from the data. It never changes bits 0 and 8, it never sets bits 1 and 3, and data in the reserved bit positions has no effect.
- R4: Writing 1 to bit 1 or bit 3 clears that change flag. Writing 0 leaves the flag unchanged.
- R5: A write that moves bit 9 from 0 to 1 raises dev_reset_req for that port. The request is high in the cycle after the write and lasts one cycle. A write that leaves bit 9 at 1 raises no request.
- R6: An attach strobe sets bits 0 and 1 and loads bit 8 from the low-speed input.
- R7: A detach strobe on a connected port clears bit 0 and sets bit 1. If the port is enabled, the strobe also clears bit 2 and sets bit 3. A detach on a port that is not connected leaves bits 0 and 1 unchanged.
- R8: A bus_reset pulse raises dev_reset_req in the next cycle on every connected port, and on no port that is not connected.
- R9: Reading an index with no port behind it returns 0xFF7F. A write to such an index changes no port.
- R10: When an attach and a write reach the same port in the same cycle, both take effect. The hardware set of a change flag wins over a write-1-to-clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | IDX_W | Port index for the write |
| wr_data | input | 16 | Write data |
| rd_idx | input | IDX_W | Port index for the read |
| rd_data | output | 16 | Read data for rd_idx (combinational) |
| attach | input | NUM_PORTS | Per-port device arrival strobe |
| attach_low_speed | input | NUM_PORTS | Speed of the arriving device, 1 = low speed |
| detach | input | NUM_PORTS | Per-port device departure strobe |
| bus_reset | input | 1 | Bus-wide reset command |
| dev_reset_req | output | NUM_PORTS | One-cycle reset request toward each port's device |

## Verification
Register state changes at the clock edge that samples a write or strobe, and rd_data follows combinationally. The bench therefore drives each stimulus after a falling edge and reads the word after the next falling edge, one cycle later. dev_reset_req is registered at that same edge, so it is checked at that same falling edge. It is checked low again one cycle further on to confirm the pulse width. The sweep walks all sixteen combinations of the four writable and clearable bits, with reserved-bit noise added, against a value computed field by field in the bench.

// File: rtl/port_sc_bank.sv
module port_sc_bank #(
  parameter int NUM_PORTS = 2,
  parameter int IDX_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [15:0]          wr_data,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [15:0]          rd_data,
  input  logic [NUM_PORTS-1:0] attach,
  input  logic [NUM_PORTS-1:0] attach_low_speed,
  input  logic [NUM_PORTS-1:0] detach,
  input  logic                 bus_reset,
  output logic [NUM_PORTS-1:0] dev_reset_req
);
  localparam logic [15:0] ABSENT = 16'hFF7F;

  logic [NUM_PORTS-1:0] ccs_v, csc_v, en_v, enc_v, lsda_v, prst_v;
  logic [15:0] view [NUM_PORTS];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic ccs, csc, en, enc, lsda, prst, req;
    logic hit, en_w, gone;

    assign hit  = wr_en && (wr_idx == IDX_W'(p));
    assign en_w = hit ? wr_data[2] : en;
    assign gone = detach[p] && !attach[p];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ccs  <= 1'b0;
        csc  <= 1'b0;
        en   <= 1'b0;
        enc  <= 1'b0;
        lsda <= 1'b0;
        prst <= 1'b0;
        req  <= 1'b0;
      end else begin
        ccs  <= attach[p] | (ccs & ~detach[p]);
        csc  <= attach[p] | (gone & ccs) | (csc & ~(hit & wr_data[1]));
        en   <= en_w & ~gone;
        enc  <= (gone & en_w) | (enc & ~(hit & wr_data[3]));
        lsda <= attach[p] ? attach_low_speed[p] : lsda;
        prst <= hit ? wr_data[9] : prst;
        req  <= (hit & wr_data[9] & ~prst) | (bus_reset & ccs);
      end
    end

    assign ccs_v[p]  = ccs;
    assign csc_v[p]  = csc;
    assign en_v[p]   = en;
    assign enc_v[p]  = enc;
    assign lsda_v[p] = lsda;
    assign prst_v[p] = prst;
    assign dev_reset_req[p] = req;
    assign view[p] = {6'b0, prst, lsda, 1'b1, 3'b0, enc, en, csc, ccs};
  end

  always_comb begin
    rd_data = ABSENT;
    for (int p = 0; p < NUM_PORTS; p++)
      if (rd_idx == IDX_W'(p)) rd_data = view[p];
  end
endmodule

module port_sc_bank_chk #(
  parameter int NUM_PORTS = 2,
  parameter int IDX_W = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [IDX_W-1:0]     wr_idx,
  input logic [15:0]          wr_data,
  input logic [IDX_W-1:0]     rd_idx,
  input logic [15:0]          rd_data,
  input logic [NUM_PORTS-1:0] attach,
  input logic [NUM_PORTS-1:0] detach,
  input logic                 bus_reset,
  input logic [NUM_PORTS-1:0] dev_reset_req,
  input logic [NUM_PORTS-1:0] ccs_v,
  input logic [NUM_PORTS-1:0] csc_v,
  input logic [NUM_PORTS-1:0] prst_v
);
  // R9
  absent_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_idx) >= NUM_PORTS) |-> rd_data == 16'hFF7F);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    // R6
    attach_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      attach[p] |=> ccs_v[p] && csc_v[p]);
    // R7
    detach_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      detach[p] && !attach[p] && ccs_v[p] |=> !ccs_v[p] && csc_v[p]);
    // R3
    connect_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !attach[p] && !detach[p] |=> $stable(ccs_v[p]));
    // R5
    reset_edge_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_idx == IDX_W'(p) && wr_data[9] && !prst_v[p] |=> dev_reset_req[p]);
    // R8
    bus_reset_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset && ccs_v[p] |=> dev_reset_req[p]);
    // R4
    change_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_idx == IDX_W'(p) && wr_data[1] && !attach[p] && !detach[p] |=> !csc_v[p]);
  end
endmodule

bind port_sc_bank port_sc_bank_chk #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .rd_idx(rd_idx), .rd_data(rd_data), .attach(attach), .detach(detach),
  .bus_reset(bus_reset), .dev_reset_req(dev_reset_req),
  .ccs_v(ccs_v), .csc_v(csc_v), .prst_v(prst_v));

// File: tb/port_sc_bank_test.sv
module port_sc_bank_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_idx = '0;
  logic [15:0] wr_data = '0;
  logic [1:0] rd_idx = '0;
  logic [15:0] rd_data;
  logic [1:0] attach = '0, attach_low_speed = '0, detach = '0;
  logic bus_reset = 1'b0;
  logic [1:0] dev_reset_req;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  port_sc_bank #(.NUM_PORTS(2), .IDX_W(2)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .attach(attach),
    .attach_low_speed(attach_low_speed), .detach(detach),
    .bus_reset(bus_reset), .dev_reset_req(dev_reset_req));

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] idx, output logic [15:0] v);
    rd_idx = idx;
    #1 v = rd_data;
  endtask

  task automatic wr(input logic [1:0] idx, input logic [15:0] d);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  function automatic logic [15:0] word(input logic ccs, csc, en, enc, ls, pr);
    return {6'b0, pr, ls, 1'b1, 3'b0, enc, en, csc, ccs};
  endfunction

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: got 0x0000 expected 0x0001");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic m_csc, m_en, m_prst;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R2
    rd(0, v); chk("R1 port0 reset", v, 16'h0080);
    rd(1, v); chk("R1 port1 reset", v, 16'h0080);
    chk("R1 no request", {14'b0, dev_reset_req}, 16'h0000);
    // R9
    rd(2, v); chk("R9 idx2", v, 16'hFF7F);
    rd(3, v); chk("R9 idx3", v, 16'hFF7F);
    wr(3, 16'hFFFF);
    rd(0, v); chk("R9 write ignored p0", v, 16'h0080);
    rd(1, v); chk("R9 write ignored p1", v, 16'h0080);
    chk("R9 no request", {14'b0, dev_reset_req}, 16'h0000);
    // R3 / R5
    wr(0, 16'hFFFF);
    rd(0, v); chk("R3 all-ones write", v, 16'h0284);
    chk("R5 request on rise", {14'b0, dev_reset_req}, 16'h0001);
    @(negedge clk);
    chk("R5 one cycle", {14'b0, dev_reset_req}, 16'h0000);
    wr(0, 16'h0200);
    chk("R5 no request when held", {14'b0, dev_reset_req}, 16'h0000);
    rd(0, v); chk("R3 enable cleared", v, 16'h0280);
    wr(0, 16'h0000);
    rd(0, v); chk("R3 cleared", v, 16'h0080);
    // R6
    attach = 2'b10; attach_low_speed = 2'b10;
    @(negedge clk);
    attach = 2'b01; attach_low_speed = 2'b00;
    @(negedge clk);
    attach = '0;
    rd(1, v); chk("R6 low-speed attach", v, 16'h0183);
    rd(0, v); chk("R6 full-speed attach", v, 16'h0083);
    // R3 R4 R5 sweep
    m_csc = 1'b1; m_en = 1'b0; m_prst = 1'b0;
    for (int s = 0; s < 16; s++) begin
      logic [15:0] d;
      logic exp_req;
      d = (16'(s & 1) << 1) | (16'((s >> 1) & 1) << 2) | (16'((s >> 2) & 1) << 3)
        | (16'((s >> 3) & 1) << 9) | ((s % 2 == 1) ? 16'hFDF1 : 16'h0000);
      exp_req = d[9] & ~m_prst;
      m_csc = m_csc & ~d[1];
      m_en = d[2];
      m_prst = d[9];
      wr(0, d);
      rd(0, v); chk("R4 R3 sweep word", v, word(1'b1, m_csc, m_en, 1'b0, 1'b0, m_prst));
      chk("R5 sweep request", {15'b0, dev_reset_req[0]}, {15'b0, exp_req});
    end
    // R7
    wr(0, 16'h0004);
    detach = 2'b01;
    @(negedge clk);
    detach = '0;
    rd(0, v); chk("R7 detach enabled", v, 16'h008A);
    detach = 2'b01;
    @(negedge clk);
    detach = '0;
    rd(0, v); chk("R7 detach idle", v, 16'h008A);
    wr(0, 16'h0008);
    rd(0, v); chk("R4 clear enable change", v, 16'h0082);
    wr(0, 16'h0002);
    rd(0, v); chk("R4 clear connect change", v, 16'h0080);
    // R8
    bus_reset = 1'b1;
    @(negedge clk);
    bus_reset = 1'b0;
    chk("R8 connected only", {14'b0, dev_reset_req}, 16'h0002);
    @(negedge clk);
    chk("R8 pulse ends", {14'b0, dev_reset_req}, 16'h0000);
    // R10
    attach = 2'b01;
    wr(0, 16'h0006);
    attach = '0;
    rd(0, v); chk("R10 attach with write", v, 16'h0087);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule